// File: doc/BRIEF.md
# Per-Pin Input Qualification Filter

This block sits between a bank of pad inputs and the logic that reads pin levels or watches them for interrupts. Every pad input first passes through a synchroniser. Each pin can then be left unfiltered. It can instead use a short glitch filter that samples on every main-clock cycle. The third choice is a debounce filter that samples only on a slow tick divided down from the main clock. The block outputs the qualified level of every pin.

Control works through write-one pulse vectors, one bit per pin. One pair of vectors turns the filter on and off. A second pair picks the filter type. A shared divider value, written with a strobe, sets the slow tick period for every pin in debounce mode. The intended setup order for debounce is to choose the type, write the divider, and then enable the filter.

Each pin runs its own three-state machine:
- FLT_BYPASS: the filter is off and the register follows the synchronised input.
- FLT_SETTLED: the filter is on and the input agrees with the held level.
- FLT_PENDING: one sample has disagreed with the held level.

The transitions are:
- Any state goes to FLT_BYPASS when the filter is disabled.
- FLT_BYPASS and FLT_SETTLED go to FLT_PENDING on a sample that differs from the held level. Otherwise they go to FLT_SETTLED.
- FLT_PENDING goes to FLT_SETTLED on the next sample. If that sample still differs, the new level is accepted.

Top module: `pin_input_filter`

## Requirements
- R1: After reset, every filter is disabled, every pin is in glitch mode, the divider is 0, and each output equals its synchronised input (0 straight after reset).
- R2: With its filter disabled, a pin's output equals its pad input delayed by exactly two clock cycles.
- R3: A 1 in bit i of `flt_en_set` enables the filter of pin i from the next cycle on. A 1 in bit i of `flt_en_clr` disables it. When both bits are 1 in the same cycle, clear wins.
- R4: A 1 in bit i of `mode_debounce_set` puts pin i in debounce mode. A 1 in bit i of `mode_glitch_set` puts it in glitch mode. When both bits are 1, glitch mode wins.
- R5: A `div_wr` pulse stores `div_val` as the divider D. The slow tick fires once every 2*(D+1) clock cycles, counted from reset or from the previous tick.
- R6: In glitch mode with the filter on, a new level is accepted only when two consecutive clock samples of the synchronised input show it. A pad change held long enough reaches the output exactly four cycles after it is applied. A one-cycle pulse never reaches the output.
- R7: In debounce mode with the filter on, a new level is accepted only when the samples at two consecutive slow ticks show it. The output therefore changes only in the cycle after a tick.
- R8: Pins are independent. Stimulus and control bits for one pin never change the output of another pin.
- R9: Disabling the filter on a pin makes its output equal its synchronised input from the next cycle, even while a change is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NPINS | Raw pad levels, asynchronous to clk |
| flt_en_set | input | NPINS | Write-one pulse: enable the filter per pin |
| flt_en_clr | input | NPINS | Write-one pulse: disable the filter per pin (wins over set) |
| mode_glitch_set | input | NPINS | Write-one pulse: select glitch mode per pin (wins over debounce) |
| mode_debounce_set | input | NPINS | Write-one pulse: select debounce mode per pin |
| div_wr | input | 1 | Strobe that loads the shared divider |
| div_val | input | DIV_W | Divider value loaded on div_wr |
| pin_out | output | NPINS | Qualified pin levels |

## Verification
The bench builds the block with NPINS=8 and DIV_W=4. With eight pins, the glitch and debounce groups can run side by side on disjoint pins, so cross-pin independence can be observed. The 4-bit divider lets the bench reach the full-scale value of 15, a 32-cycle tick. The bench then confirms the earliest and latest debounce acceptance for that value. It also exercises the divider wrap, where the counter already exceeds a newly written smaller limit.

// File: rtl/pif_pkg.sv
package pif_pkg;

    typedef enum logic [1:0] {
        FLT_BYPASS  = 2'd0,
        FLT_SETTLED = 2'd1,
        FLT_PENDING = 2'd2
    } flt_state_e;

endpackage

// File: rtl/pif_pad_sync.sv
module pif_pad_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= d_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/pif_ctrl_regs.sv
module pif_ctrl_regs #(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] en_set,
    input  logic [NPINS-1:0] en_clr,
    input  logic [NPINS-1:0] glitch_set,
    input  logic [NPINS-1:0] debounce_set,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic [NPINS-1:0] en_q,
    output logic [NPINS-1:0] deb_q,
    output logic [DIV_W-1:0] div_q
);

    logic [NPINS-1:0] en_d;
    logic [NPINS-1:0] deb_d;

    always_comb begin
        en_d  = (en_q | en_set) & ~en_clr;
        deb_d = (deb_q | debounce_set) & ~glitch_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            deb_q <= '0;
            div_q <= '0;
        end else begin
            en_q  <= en_d;
            deb_q <= deb_d;
            if (div_wr) begin
                div_q <= div_val;
            end
        end
    end

endmodule

// File: rtl/pif_tick_gen.sv
module pif_tick_gen #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    output logic             tick
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = {div_q, 1'b1};
        tick  = (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pif_filter_cell.sv
module pif_filter_cell
    import pif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    input  logic level,
    output logic qual
);

    flt_state_e state_q;
    flt_state_e state_d;
    logic       held_q;
    logic       held_d;
    logic       differs;

    always_comb begin
        differs = (level != held_q);
        state_d = state_q;
        held_d  = held_q;
        if (!enable) begin
            state_d = FLT_BYPASS;
            held_d  = level;
        end else if (strobe) begin
            unique case (state_q)
                FLT_BYPASS, FLT_SETTLED: begin
                    state_d = differs ? FLT_PENDING : FLT_SETTLED;
                end
                FLT_PENDING: begin
                    state_d = FLT_SETTLED;
                    if (differs) begin
                        held_d = level;
                    end
                end
                default: begin
                    state_d = FLT_BYPASS;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_BYPASS;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        qual = enable ? held_q : level;
    end

endmodule

// File: rtl/pin_input_filter.sv
module pin_input_filter #(
    parameter int NPINS       = 32,
    parameter int DIV_W       = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] flt_en_set,
    input  logic [NPINS-1:0] flt_en_clr,
    input  logic [NPINS-1:0] mode_glitch_set,
    input  logic [NPINS-1:0] mode_debounce_set,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic [NPINS-1:0] pin_out
);

    logic [NPINS-1:0] pad_s;
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] deb_q;
    logic [DIV_W-1:0] div_q;
    logic             slow_tick;

    pif_pad_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pad_s)
    );

    pif_ctrl_regs #(
        .NPINS (NPINS),
        .DIV_W (DIV_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_set       (flt_en_set),
        .en_clr       (flt_en_clr),
        .glitch_set   (mode_glitch_set),
        .debounce_set (mode_debounce_set),
        .div_wr       (div_wr),
        .div_val      (div_val),
        .en_q         (en_q),
        .deb_q        (deb_q),
        .div_q        (div_q)
    );

    pif_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div_q (div_q),
        .tick  (slow_tick)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic strobe;
        assign strobe = deb_q[p] ? slow_tick : 1'b1;

        pif_filter_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (en_q[p]),
            .strobe (strobe),
            .level  (pad_s[p]),
            .qual   (pin_out[p])
        );
    end

endmodule

// File: rtl/pin_input_filter_chk.sv
module pin_input_filter_chk #(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] flt_en_clr,
    input logic             div_wr,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pad_s,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] deb_q,
    input logic [DIV_W-1:0] div_q,
    input logic             slow_tick
);

    logic [1:0]     since_rst;
    logic [DIV_W:0] gap_q;
    logic           div_touched;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst   <= '0;
            gap_q       <= '0;
            div_touched <= 1'b0;
        end else begin
            if (since_rst != 2'd3) begin
                since_rst <= since_rst + 2'd1;
            end
            gap_q       <= slow_tick ? '0 : gap_q + 1'b1;
            div_touched <= slow_tick ? 1'b0 : (div_touched | div_wr);
        end
    end

    AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && en_q == '0) |-> (pin_out == $past(pad_in, 2))); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_en_clr != '0) |=> ((en_q & $past(flt_en_clr)) == '0)); // R3

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && !div_touched) |-> (gap_q == {div_q, 1'b1})); // R5

    for (genvar p = 0; p < NPINS; p++) begin : g_pin_chk
        AST_GLITCH_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && en_q[p] && $past(en_q[p]) && $past(en_q[p], 2)
             && !$past(deb_q[p]) && !$past(deb_q[p], 2)
             && pin_out[p] != $past(pin_out[p]))
            |-> ($past(pad_s[p]) == pin_out[p] && $past(pad_s[p], 2) == pin_out[p])); // R6

        AST_DEBOUNCE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst != 2'd0 && en_q[p] && $past(en_q[p]) && $past(deb_q[p])
             && pin_out[p] != $past(pin_out[p]))
            |-> $past(slow_tick)); // R7

        AST_DISABLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[p]) |-> (pin_out[p] == pad_s[p])); // R9
    end

endmodule

bind pin_input_filter pin_input_filter_chk #(
    .NPINS (NPINS),
    .DIV_W (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_in     (pad_in),
    .flt_en_clr (flt_en_clr),
    .div_wr     (div_wr),
    .pin_out    (pin_out),
    .pad_s      (pad_s),
    .en_q       (en_q),
    .deb_q      (deb_q),
    .div_q      (div_q),
    .slow_tick  (slow_tick)
);

// File: tb/test_pin_input_filter.sv
module test_pin_input_filter;

    localparam int NP = 8;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] flt_en_set = '0;
    logic [NP-1:0] flt_en_clr = '0;
    logic [NP-1:0] mode_glitch_set = '0;
    logic [NP-1:0] mode_debounce_set = '0;
    logic          div_wr = 1'b0;
    logic [DW-1:0] div_val = '0;
    logic [NP-1:0] pin_out;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [NP-1:0] m_pipe[$];
    logic [NP-1:0] m_en, m_deb, m_held, m_pend;
    int            m_div, m_cnt;

    always #4 clk = ~clk;

    pin_input_filter #(
        .NPINS       (NP),
        .DIV_W       (DW),
        .SYNC_STAGES (2)
    ) i_pin_input_filter (
        .clk               (clk),
        .rst_n             (rst_n),
        .pad_in            (pad_in),
        .flt_en_set        (flt_en_set),
        .flt_en_clr        (flt_en_clr),
        .mode_glitch_set   (mode_glitch_set),
        .mode_debounce_set (mode_debounce_set),
        .div_wr            (div_wr),
        .div_val           (div_val),
        .pin_out           (pin_out)
    );

    task automatic check(input logic [NP-1:0] act, input logic [NP-1:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NP-1:0] model_out();
        return (m_en & m_held) | (~m_en & m_pipe[1]);
    endfunction

    task automatic step();
        logic [NP-1:0] s2, nh, np;
        bit tk;
        s2 = m_pipe[1];
        tk = (m_cnt >= 2 * m_div + 1);
        nh = m_held;
        np = m_pend;
        for (int i = 0; i < NP; i++) begin
            if (!m_en[i]) begin
                nh[i] = s2[i];
                np[i] = 1'b0;
            end else if (!m_deb[i] || tk) begin
                if (s2[i] != m_held[i]) begin
                    if (m_pend[i]) begin
                        nh[i] = s2[i];
                        np[i] = 1'b0;
                    end else begin
                        np[i] = 1'b1;
                    end
                end else begin
                    np[i] = 1'b0;
                end
            end
        end
        m_held = nh;
        m_pend = np;
        m_cnt  = tk ? 0 : m_cnt + 1;
        m_en   = (m_en | flt_en_set) & ~flt_en_clr;
        m_deb  = (m_deb | mode_debounce_set) & ~mode_glitch_set;
        if (div_wr) m_div = int'(div_val);
        m_pipe.push_front(pad_in);
        void'(m_pipe.pop_back());
        @(posedge clk);
        @(negedge clk);
        check(pin_out, model_out(), cur_req);
        flt_en_set        = '0;
        flt_en_clr        = '0;
        mode_glitch_set   = '0;
        mode_debounce_set = '0;
        div_wr            = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        m_pipe = '{'0, '0};
        m_en = '0; m_deb = '0; m_held = '0; m_pend = '0;
        m_div = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        check(pin_out, '0, "R1");

        // R2: bypass latency of two cycles
        cur_req = "R2";
        pad_in = 8'hA5;
        step();
        check(pin_out, 8'h00, "R2");
        step();
        check(pin_out, 8'hA5, "R2");

        // R6: glitch filter on pins 0..3 (default glitch mode after reset, R1)
        cur_req = "R6";
        flt_en_set = 8'h0F;
        steps(4);
        pad_in[1] = 1'b1;
        step();
        pad_in[1] = 1'b0;
        steps(6);
        check({7'd0, pin_out[1]}, 8'd0, "R6");
        pad_in[1] = 1'b1;
        steps(3);
        check({7'd0, pin_out[1]}, 8'd0, "R6");
        step();
        check({7'd0, pin_out[1]}, 8'd1, "R6");
        pad_in[2] = 1'b1;
        steps(2);
        pad_in[2] = 1'b0;
        steps(6);

        // R3: set and clear together, clear wins
        cur_req = "R3";
        flt_en_set = 8'h10;
        flt_en_clr = 8'h10;
        step();
        pad_in[4] = ~pad_in[4];
        steps(2);
        check({7'd0, pin_out[4]}, {7'd0, pad_in[4]}, "R3");

        // R9: disabling while a change is pending
        cur_req = "R9";
        pad_in[3] = 1'b1;
        steps(3);
        flt_en_clr = 8'h08;
        step();
        check({7'd0, pin_out[3]}, 8'd1, "R9");
        pad_in[3] = 1'b0;
        steps(2);
        check({7'd0, pin_out[3]}, 8'd0, "R9");

        // R7: debounce on pins 4..7, small divider
        cur_req = "R7";
        mode_debounce_set = 8'hF0;
        div_wr  = 1'b1;
        div_val = 4'd1;
        step();
        flt_en_set = 8'hF0;
        steps(10);
        pad_in[5] = ~pad_in[5];
        steps(20);
        check({7'd0, pin_out[5]}, {7'd0, pad_in[5]}, "R7");
        for (int k = 0; k < 6; k++) begin
            pad_in[6] = ~pad_in[6];
            steps(k + 1);
        end
        steps(20);

        // R5: full-scale divider, acceptance window for pin 7
        cur_req = "R5";
        div_wr  = 1'b1;
        div_val = 4'd15;
        step();
        steps(70);
        pad_in[7] = ~pad_in[7];
        steps(34);
        check({7'd0, pin_out[7]}, {7'd0, ~pad_in[7]}, "R5");
        steps(32);
        check({7'd0, pin_out[7]}, {7'd0, pad_in[7]}, "R5");

        // R4: both type selects on pin 6, glitch wins
        cur_req = "R4";
        mode_glitch_set   = 8'h40;
        mode_debounce_set = 8'h40;
        step();
        steps(70);
        pad_in[6] = ~pad_in[6];
        steps(3);
        check({7'd0, pin_out[6]}, {7'd0, ~pad_in[6]}, "R4");
        step();
        check({7'd0, pin_out[6]}, {7'd0, pad_in[6]}, "R4");

        // R5: divider shrink while counter is past the new limit
        cur_req = "R5";
        steps(20);
        div_wr  = 1'b1;
        div_val = 4'd2;
        step();
        steps(40);

        // R8: random independent stimulus across all pins
        cur_req = "R8";
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < NP; i++) begin
                if ($urandom_range(0, 9) == 0) pad_in[i] = ~pad_in[i];
            end
            if ($urandom_range(0, 40) == 0) flt_en_set = NP'($urandom);
            if ($urandom_range(0, 60) == 0) flt_en_clr = NP'($urandom);
            if ($urandom_range(0, 50) == 0) mode_glitch_set = NP'($urandom);
            if ($urandom_range(0, 50) == 0) mode_debounce_set = NP'($urandom);
            if ($urandom_range(0, 150) == 0) begin
                div_wr  = 1'b1;
                div_val = DW'($urandom_range(0, 3));
            end
            step();
        end

        finish_run();
    end

endmodule